// File: doc/BRIEF.md
# Label Area Read/Write Engine

This block owns a small byte-addressed label storage area inside the chip and serves two commands against it. A read command carries an 8-byte header that names a starting byte and a byte count. The block streams those bytes out one per cycle. A write command carries the same 8-byte header shape, holding the starting byte and a reserved word, followed by data bytes. The block pulls the data bytes in one per cycle, by index, from the caller's payload buffer and stores them at the starting byte.

Every command ends with a single-cycle completion strobe that carries a return code and an output length. Before any byte moves, the block checks the bounds using sums one bit wider than the operands, so an offset close to the top of the 32-bit range cannot wrap around and pass the check. A command that fails the check moves no data. A command that passes it but has nothing to move finishes at once.

Top module: `lbl_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_vld` and `wr_req` are all low.
- R2: A read whose payload length is not exactly 8 completes with return code 0x16, output length 0, and no data beat.
- R3: A read where offset + length > `LBL_BYTES` completes with return code 0x02, output length 0, and no data beat. The header is little-endian: `cmd_hdr[31:0]` holds the offset (payload bytes 0–3) and `cmd_hdr[63:32]` holds the length (payload bytes 4–7).
- R4: A valid read raises `rd_vld` for exactly `length` consecutive cycles. Beat k carries `rd_idx` = k and the area byte at offset + k. The read completes with return code 0x00 and output length equal to the requested length.
- R5: A write with a total payload length of 0 completes with return code 0x00 and leaves the area unchanged.
- R6: A write with a total payload length from 1 to 7 cannot hold the header, so it is rejected with return code 0x02 and writes nothing.
- R7: A write where offset + total length > `LBL_BYTES` + 8 is rejected with return code 0x02 and writes nothing.
- R8: An accepted write stores (total length − 8) bytes starting at the offset. Beat k raises `wr_req` with `wr_idx` = k and stores `wr_byte` at offset + k. A write always reports output length 0.
- R9: `done` is a one-cycle pulse. It comes N+1 cycles after the accepting clock edge when N bytes move, and 1 cycle after that edge when nothing moves.
- R10: `cmd_valid` is ignored while `busy` is high.
- R11: Offset + length is evaluated without 32-bit wraparound. For example, offset 0xFFFFFFFF with a read length of 2 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe; taken only when idle |
| cmd_wr | input | 1 | 1 = write command, 0 = read command |
| cmd_len | input | LEN_W | Total payload length in bytes, including the header |
| cmd_hdr | input | 64 | Header bytes 0–7, little-endian; byte 0 is in bits [7:0] |
| wr_req | output | 1 | Write beat: `wr_byte` is consumed on this cycle |
| wr_idx | output | LEN_W | Index of the data byte requested (payload byte 8 + index) |
| wr_byte | input | 8 | Data byte returned for `wr_idx` |
| rd_vld | output | 1 | Read beat valid |
| rd_idx | output | LEN_W | Index of the read beat |
| rd_byte | output | 8 | Read data byte |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Completion pulse |
| ret_code | output | 8 | Return code, valid with `done` |
| out_len | output | 32 | Output length, valid with `done` |

## Verification
The bench takes the clock edge that accepts a command as cycle 0 and samples at each following falling edge. Data beats are expected in cycles 1 to N and the completion pulse in cycle N+1. A command that moves nothing must complete in cycle 1. Every beat is compared on its own cycle against a bench copy of the area. The completion's cycle number, code and length are all checked, and the falling edge after the pulse must show the block idle again. Writes that are rejected or empty, and writes offered while a read is busy, are proved harmless by reading the affected region back through the normal read path.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
   localparam int HDR_BYTES = 8;
   localparam logic [7:0] RC_OK      = 8'h00;
   localparam logic [7:0] RC_BAD_IN  = 8'h02;
   localparam logic [7:0] RC_BAD_LEN = 8'h16;
   typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_DONE} lbl_state_e;
endpackage

// File: rtl/lbl_bounds.sv
module lbl_bounds #(
   parameter int LBL_BYTES = 256,
   parameter int LEN_W     = 16
) (
   input  logic             is_wr,
   input  logic [LEN_W-1:0] pl_len,
   input  logic [31:0]      off,
   input  logic [31:0]      rlen,
   output logic [7:0]       rc,
   output logic [LEN_W-1:0] n_bytes,
   output logic [31:0]      o_len
);
   import lbl_pkg::*;
   localparam logic [32:0] RD_LIM = 33'(LBL_BYTES);
   localparam logic [32:0] WR_LIM = 33'(LBL_BYTES + HDR_BYTES);
   localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);

   logic [32:0] wr_end, rd_end;

   always_comb begin
      // one spare bit keeps the sum from wrapping
      wr_end  = {1'b0, off} + 33'(pl_len);
      rd_end  = {1'b0, off} + {1'b0, rlen};
      rc      = RC_OK;
      n_bytes = '0;
      o_len   = '0;
      if (is_wr) begin
         if (pl_len == '0) begin
            rc = RC_OK;
         end else if (pl_len < HDR_L || wr_end > WR_LIM) begin
            rc = RC_BAD_IN;
         end else begin
            n_bytes = pl_len - HDR_L;
         end
      end else begin
         if (pl_len != HDR_L) begin
            rc = RC_BAD_LEN;
         end else if (rd_end > RD_LIM) begin
            rc = RC_BAD_IN;
         end else begin
            n_bytes = rlen[LEN_W-1:0];
            o_len   = rlen;
         end
      end
   end
endmodule

// File: rtl/lbl_store.sv
module lbl_store #(
   parameter int LBL_BYTES = 256,
   parameter int AW        = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   logic [7:0] arr [LBL_BYTES];

   always_ff @(posedge clk) begin
      if (we) arr[addr] <= wdata;
   end

   generate
      if (LBL_BYTES == (1 << AW)) begin : g_pow2
         assign rdata = arr[addr];
      end else begin : g_odd
         assign rdata = (32'(addr) < LBL_BYTES) ? arr[addr] : 8'h00;
      end
   endgenerate
endmodule

// File: rtl/lbl_seq.sv
module lbl_seq #(
   parameter int LEN_W = 16,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             is_wr_in,
   input  logic [AW-1:0]    base_in,
   input  logic [LEN_W-1:0] n_in,
   input  logic [7:0]       rc_in,
   input  logic [31:0]      olen_in,
   output logic             busy,
   output logic             done,
   output logic             xfer,
   output logic             is_wr,
   output logic [LEN_W-1:0] idx,
   output logic [AW-1:0]    addr,
   output logic [7:0]       rc,
   output logic [31:0]      olen
);
   import lbl_pkg::*;
   lbl_state_e       st;
   logic [AW-1:0]    base_q;
   logic [LEN_W-1:0] n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         is_wr  <= 1'b0;
         base_q <= '0;
         n_q    <= '0;
         idx    <= '0;
         rc     <= RC_OK;
         olen   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               is_wr  <= is_wr_in;
               base_q <= base_in;
               n_q    <= n_in;
               idx    <= '0;
               rc     <= rc_in;
               olen   <= olen_in;
               st     <= (rc_in == RC_OK && n_in != '0) ? ST_MOVE : ST_DONE;
            end
            ST_MOVE: begin
               idx <= idx + 1'b1;
               if (idx == n_q - 1'b1) st <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
   assign done = (st == ST_DONE);
   assign xfer = (st == ST_MOVE);
   assign addr = base_q + idx[AW-1:0];
endmodule

// File: rtl/lbl_engine.sv
module lbl_engine #(
   parameter int LBL_BYTES = 256,
   parameter int LEN_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_wr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [63:0]      cmd_hdr,
   output logic             wr_req,
   output logic [LEN_W-1:0] wr_idx,
   input  logic [7:0]       wr_byte,
   output logic             rd_vld,
   output logic [LEN_W-1:0] rd_idx,
   output logic [7:0]       rd_byte,
   output logic             busy,
   output logic             done,
   output logic [7:0]       ret_code,
   output logic [31:0]      out_len
);
   localparam int AW = (LBL_BYTES < 2) ? 1 : $clog2(LBL_BYTES);

   generate
      if (LBL_BYTES < 2) begin : g_bad_size
         $error("LBL_BYTES must be at least 2");
      end
      if (LEN_W < 4 || LEN_W > 31) begin : g_bad_lw
         $error("LEN_W must lie in 4..31");
      end else if (64'(LBL_BYTES) + 64'd8 >= (64'd1 << LEN_W)) begin : g_small_lw
         $error("LEN_W too narrow for LBL_BYTES plus header");
      end
   endgenerate

   logic             start, xfer, q_wr;
   logic [7:0]       chk_rc;
   logic [LEN_W-1:0] chk_n, idx;
   logic [31:0]      chk_olen;
   logic [AW-1:0]    addr;

   assign start = cmd_valid & ~busy;

   lbl_bounds #(.LBL_BYTES(LBL_BYTES), .LEN_W(LEN_W)) bounds_i (
      .is_wr(cmd_wr), .pl_len(cmd_len), .off(cmd_hdr[31:0]), .rlen(cmd_hdr[63:32]),
      .rc(chk_rc), .n_bytes(chk_n), .o_len(chk_olen));

   lbl_seq #(.LEN_W(LEN_W), .AW(AW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .is_wr_in(cmd_wr),
      .base_in(cmd_hdr[AW-1:0]), .n_in(chk_n), .rc_in(chk_rc), .olen_in(chk_olen),
      .busy(busy), .done(done), .xfer(xfer), .is_wr(q_wr), .idx(idx),
      .addr(addr), .rc(ret_code), .olen(out_len));

   lbl_store #(.LBL_BYTES(LBL_BYTES), .AW(AW)) store_i (
      .clk(clk), .we(wr_req), .addr(addr), .wdata(wr_byte), .rdata(rd_byte));

   assign wr_req = xfer & q_wr;
   assign rd_vld = xfer & ~q_wr;
   assign wr_idx = idx;
   assign rd_idx = idx;
endmodule

// File: rtl/lbl_engine_chk.sv
module lbl_engine_chk #(
   parameter int LBL_BYTES = 256,
   parameter int LEN_W     = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             wr_req,
   input logic             rd_vld,
   input logic [LEN_W-1:0] rd_idx,
   input logic             busy,
   input logic             done,
   input logic [7:0]       ret_code,
   input logic [31:0]      out_len
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |=> (done || (rd_vld && rd_idx == LEN_W'($past(rd_idx) + 1'b1))));

   // R4
   rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |-> (32'(rd_idx) < LBL_BYTES) && !wr_req);

   // R3
   rej_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ret_code != 8'h00) |-> out_len == 32'd0);

   // R8
   wr_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> (wr_req || (done && out_len == 32'd0 && ret_code == 8'h00)));

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && busy && !done) |=> busy);
endmodule

bind lbl_engine lbl_engine_chk #(.LBL_BYTES(LBL_BYTES), .LEN_W(LEN_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_req(wr_req),
   .rd_vld(rd_vld), .rd_idx(rd_idx), .busy(busy), .done(done),
   .ret_code(ret_code), .out_len(out_len));

// File: tb/lbl_engine_tb_top.sv
module lbl_engine_tb_top;
   localparam int SZ = 256;
   localparam int LW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          cmd_valid = 1'b0, cmd_wr = 1'b0;
   logic [LW-1:0] cmd_len = '0;
   logic [63:0]   cmd_hdr = '0;
   logic          wr_req, rd_vld, busy, done;
   logic [LW-1:0] wr_idx, rd_idx;
   logic [7:0]    wr_byte, rd_byte, ret_code;
   logic [31:0]   out_len;

   logic [7:0] model [SZ];
   logic [7:0] pl [512];
   int errors = 0, checks = 0, cyc = 0;

   assign wr_byte = pl[wr_idx[8:0]];

   lbl_engine #(.LBL_BYTES(SZ), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
      .cmd_len(cmd_len), .cmd_hdr(cmd_hdr), .wr_req(wr_req), .wr_idx(wr_idx),
      .wr_byte(wr_byte), .rd_vld(rd_vld), .rd_idx(rd_idx), .rd_byte(rd_byte),
      .busy(busy), .done(done), .ret_code(ret_code), .out_len(out_len));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic void expect_fn(input bit wr, input int unsigned len,
                                     input logic [31:0] off, input logic [31:0] rl,
                                     output logic [7:0] rc, output int unsigned n,
                                     output logic [31:0] ol);
      longint unsigned e;
      rc = 8'h00; n = 0; ol = 0;
      if (wr) begin
         e = 64'(off) + 64'(len);
         if (len == 0) rc = 8'h00;
         else if (len < 8 || e > SZ + 8) rc = 8'h02;
         else n = len - 8;
      end else begin
         e = 64'(off) + 64'(rl);
         if (len != 8) rc = 8'h16;
         else if (e > SZ) rc = 8'h02;
         else begin n = rl; ol = rl; end
      end
   endfunction

   task automatic fill_pl();
      for (int i = 0; i < 512; i++) pl[i] = 8'($urandom);
   endtask

   task automatic run(input bit wr, input int unsigned len, input logic [31:0] off,
                      input logic [31:0] rl, input string tag, input bit intrude);
      logic [7:0] rc; int unsigned n; logic [31:0] ol;
      int k = 0; int t = 1; int a;
      expect_fn(wr, len, off, rl, rc, n, ol);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_wr = wr; cmd_len = LW'(len); cmd_hdr = {rl, off};
      @(negedge clk);
      cmd_valid = 1'b0;
      while (done !== 1'b1 && t < 600) begin
         a = (int'(off[8:0]) + k) % SZ;
         if (rd_vld === 1'b1) begin
            chk(!wr && rd_idx == LW'(k), {tag, " R4 rd_idx"}, 64'(rd_idx), 64'(k));
            chk(rd_byte === model[a], {tag, " R4 rd_byte"}, 64'(rd_byte), 64'(model[a]));
            k++;
         end
         if (wr_req === 1'b1) begin
            chk(wr && wr_idx == LW'(k), {tag, " R8 wr_idx"}, 64'(wr_idx), 64'(k));
            model[a] = pl[k];
            k++;
         end
         if (intrude && t == 2) begin
            cmd_valid = 1'b1; cmd_wr = 1'b1; cmd_len = LW'(16); cmd_hdr = 64'h0;
         end else if (intrude && t == 3) begin
            cmd_valid = 1'b0;
         end
         @(negedge clk);
         t++;
      end
      cmd_valid = 1'b0;
      chk(done === 1'b1 && t == int'(n) + 1, {tag, " R9 done cycle"}, 64'(t), 64'(n + 1));
      chk(k == int'(n), {tag, " R4/R8 beat count"}, 64'(k), 64'(n));
      chk(ret_code == rc, {tag, " ret_code"}, 64'(ret_code), 64'(rc));
      chk(out_len == ol, {tag, " out_len"}, 64'(out_len), 64'(ol));
      @(negedge clk);
      chk(done === 1'b0 && busy === 1'b0, {tag, " R9 single pulse"}, 64'({done, busy}), 64'(0));
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired act=%0d exp<150000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      r = $urandom(1234);
      for (int i = 0; i < SZ; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && rd_vld === 1'b0 && wr_req === 1'b0,
          "R1 reset outputs", 64'({busy, done, rd_vld, wr_req}), 64'(0));
      rst_n = 1'b1;

      fill_pl();
      run(1'b1, 8 + SZ, 32'd0, 32'd0, "R8 full write", 1'b0);
      run(1'b0, 8, 32'd0, 32'(SZ), "R4 full read", 1'b0);
      run(1'b0, 7, 32'd0, 32'd4, "R2 short read", 1'b0);
      run(1'b0, 9, 32'd0, 32'd4, "R2 long read", 1'b0);
      run(1'b0, 8, 32'd250, 32'd7, "R3 read past end", 1'b0);
      run(1'b0, 8, 32'd250, 32'd6, "R4 read to end", 1'b0);
      run(1'b0, 8, 32'd5, 32'd0, "R4 zero read", 1'b0);
      run(1'b0, 8, 32'hFFFF_FFFF, 32'd2, "R11 offset wrap", 1'b0);
      run(1'b0, 8, 32'd1, 32'hFFFF_FFFF, "R11 length wrap", 1'b0);
      fill_pl();
      run(1'b1, 0, 32'd0, 32'd0, "R5 empty write", 1'b0);
      run(1'b1, 5, 32'd0, 32'd0, "R6 headerless write", 1'b0);
      run(1'b1, 8 + 7, 32'd250, 32'd0, "R7 write past end", 1'b0);
      run(1'b1, 16, 32'hFFFF_FFF8, 32'd0, "R11 write wrap", 1'b0);
      run(1'b0, 8, 32'd0, 32'd16, "R5/R6 readback", 1'b0);
      run(1'b0, 8, 32'd244, 32'd12, "R7 readback", 1'b0);
      run(1'b1, 8 + 6, 32'd250, 32'd0, "R8 write to end", 1'b0);
      run(1'b1, 8, 32'd3, 32'd0, "R8 header only", 1'b0);
      run(1'b0, 8, 32'd244, 32'd12, "R8 readback", 1'b0);
      fill_pl();
      run(1'b0, 8, 32'd100, 32'd40, "R10 busy read", 1'b1);
      run(1'b0, 8, 32'd0, 32'd16, "R10 readback", 1'b0);

      for (int i = 0; i < 60; i++) begin
         bit wr; int unsigned len; logic [31:0] off, rl;
         fill_pl();
         wr  = 1'($urandom);
         off = 32'($urandom % 300);
         if (wr) begin
            r   = $urandom % 8;
            len = (r == 0) ? 0 : (r == 1) ? 1 + $urandom % 7 : 8 + $urandom % 40;
            rl  = 32'($urandom);
         end else begin
            len = ($urandom % 8 == 0) ? 9 : 8;
            rl  = 32'($urandom % 48);
         end
         run(wr, len, off, rl, wr ? "R8 random write" : "R4 random read", 1'b0);
      end
      run(1'b0, 8, 32'd0, 32'(SZ), "R4 final sweep", 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule